// File: doc/BRIEF.md
# Burst DMA Bus Master

This block is the bus-master engine for a 32-bit bus on which address and data share the same wires. Each command asks for one burst, read or write, of 1, 2, 4, 8, 12 or 16 words. The engine requests the bus with an active-low request line and waits for an active-low grant. It then drives the start address for one clock and moves data from the next clock on. The target paces each word with an active-low ready.

The target can abort a word. When it does, the engine releases the bus and drops its request, then asks again and restarts at the aborted word with that word's address. A fatal bus-error input stops all bus activity at once. It also latches a sticky error flag, unless a mask input suppresses the flag, and the flag drives the interrupt. While the flag is set, new commands are refused until they are cleared. Configuration inputs select three things: whether parity is used, odd or even sense, and whether parity covers each byte or the whole word. A further input selects early sampling, where ready and abort are taken one clock ahead.

Write data is pulled from the layer above through a word index. Read words come back tagged with their index and a parity-error flag.

Top module: `burst_dma_master`

## Requirements
- R1: `size_o` shows the command's burst-size code: 000=1 word, 001=2, 010=4, 011=8, 100=16, 101=12. A start carrying code 110 or 111 is refused and the engine stays idle. `size_o` resets to 000.
- R2: `dir_o` is 1 for a read and 0 for a write. It resets to 1 and holds the accepted command's direction until the next command.
- R3: An accepted start leads to `req_n_o` low once `gnt_n_i` has been sampled high. The address phase is the cycle after `gnt_n_i` is sampled low. `req_n_o` returns high at the edge after which at most one word remains.
- R4: `req_n_o` only falls when `gnt_n_i` was high in the previous cycle, so a new request always follows the return of grant.
- R5: In the address phase `ad_oe_o`=1 and `ad_o`=start address + 4·index. Each write data cycle drives `wdata_i` for index `word_idx_o`. On reads, and whenever the bus is not owned, `ad_oe_o`=0.
- R6: A data word completes only in a cycle where ready is sampled active and abort is not. Completion steps the index. A completed read word appears on `rdata_o` with `rdata_vld_o` and `rdata_idx_o` one cycle later. `done_o` pulses one cycle after the last word completes.
- R7: Abort sampled active in a data cycle completes no word, whatever ready shows. The engine leaves the bus, raises `req_n_o`, and after re-grant repeats the address phase for the aborted word.
- R8: With `early_i`=1, ready and abort take effect in the cycle after the one in which they are driven. With `early_i`=0 they take effect in the same cycle.
- R9: `err_n_i` sampled low ends any activity: the next cycle has `busy_o`=0, `ad_oe_o`=0 and `req_n_o`=1. Unless `err_mask_i`=1, `err_status_o` and `irq_o` go to 1 and stay there until `err_clr_i`.
- R10: For every driven bus word, parity is produced when `par_en_i`=1. Even parity gives each bit the XOR of what it covers; odd parity inverts it. In byte mode (`par_byte_i`=1), bit b covers bits 8b+7..8b and `par_oe_o`=1111. In word mode, only bit 3 is used: it covers all 32 bits and `par_oe_o`=1000. With parity disabled, `par_oe_o`=0000.
- R11: For each completed read word, `par_err_o` (aligned with `rdata_vld_o`) is 1 when any used `par_i` bit differs from the R10 parity of `ad_i`.
- R12: A start is refused while `err_status_o`=1. After `err_clr_i`, starts are accepted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command strobe, taken when idle |
| start_addr_i | input | 32 | Burst start address |
| start_rd_i | input | 1 | 1 = read, 0 = write |
| start_size_i | input | 3 | Burst-size code (R1) |
| wdata_i | input | 32 | Write word for index `word_idx_o` |
| word_idx_o | output | 5 | Index of the current word |
| rdata_o | output | 32 | Completed read word |
| rdata_vld_o | output | 1 | `rdata_o` valid |
| rdata_idx_o | output | 5 | Index of `rdata_o` |
| par_err_o | output | 1 | Parity mismatch on `rdata_o` |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | Burst completed pulse |
| par_en_i | input | 1 | Parity enable |
| par_odd_i | input | 1 | 1 = odd parity |
| par_byte_i | input | 1 | 1 = byte parity, 0 = word parity |
| early_i | input | 1 | Early ready/abort sampling |
| err_mask_i | input | 1 | Suppress error flag |
| err_clr_i | input | 1 | Clear error flag |
| err_status_o | output | 1 | Sticky bus-error flag |
| irq_o | output | 1 | Interrupt |
| req_n_o | output | 1 | Bus request, active low |
| gnt_n_i | input | 1 | Bus grant, active low |
| rdy_n_i | input | 1 | Target ready, active low |
| abrt_n_i | input | 1 | Target abort, active low |
| err_n_i | input | 1 | Fatal bus error, active low |
| dir_o | output | 1 | Transfer direction |
| size_o | output | 3 | Burst-size code |
| ad_o | output | 32 | Address/data out |
| ad_oe_o | output | 1 | Address/data output enable |
| ad_i | input | 32 | Address/data in |
| par_o | output | 4 | Parity out |
| par_oe_o | output | 4 | Per-bit parity output enable |
| par_i | input | 4 | Parity in |

## Verification
The assertions take the arbiter at its word on two points. Grant only comes low after a request, and it goes high again once the request is withdrawn. Parity settings and early mode are also assumed not to change while a burst is in flight. The stimulus meets these assumptions with a reactive arbiter that mirrors the request line with one cycle of lag, plus an optional hold-off. Configuration inputs change only between commands. Ready, abort and error are driven at the falling edge, from the observed phase of the burst.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int unsigned LEN_W = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GAP,
    ST_REQ,
    ST_ADDR,
    ST_DATA
  } dma_st_e;

  // 0 marks an illegal code
  function automatic logic [LEN_W-1:0] code_to_len(input logic [2:0] code);
    case (code)
      3'd0:    code_to_len = LEN_W'(1);
      3'd1:    code_to_len = LEN_W'(2);
      3'd2:    code_to_len = LEN_W'(4);
      3'd3:    code_to_len = LEN_W'(8);
      3'd4:    code_to_len = LEN_W'(16);
      3'd5:    code_to_len = LEN_W'(12);
      default: code_to_len = '0;
    endcase
  endfunction
endpackage

// File: rtl/dma_parity.sv
module dma_parity #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0]   word_i,
  input  logic                en_i,
  input  logic                odd_i,
  input  logic                byte_i,
  output logic [DATA_W/8-1:0] par_o,
  output logic [DATA_W/8-1:0] use_o
);
  localparam int unsigned NB = DATA_W / 8;

  logic [NB-1:0] byte_par;
  logic          word_par;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign byte_par[b] = (^word_i[8*b +: 8]) ^ odd_i;
  end

  assign word_par = (^word_i) ^ odd_i;

  always_comb begin
    use_o = '0;
    par_o = '0;
    if (en_i) begin
      if (byte_i) begin
        use_o = '1;
        par_o = byte_par;
      end else begin
        use_o[NB-1] = 1'b1;
        par_o[NB-1] = word_par;
      end
    end
  end
endmodule

// File: rtl/dma_beat_ctr.sv
module dma_beat_ctr #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned SHIFT  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IDX_W-1:0]  len_i,
  input  logic              advance_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o,
  output logic              more_o
);
  logic [ADDR_W-1:0] base_q;
  logic [IDX_W-1:0]  len_q, idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      len_q  <= '0;
      idx_q  <= '0;
    end else if (load_i) begin
      base_q <= base_i;
      len_q  <= len_i;
      idx_q  <= '0;
    end else if (advance_i) begin
      idx_q <= idx_q + IDX_W'(1);
    end
  end

  assign idx_o  = idx_q;
  assign addr_o = base_q + (ADDR_W'(idx_q) << SHIFT);
  assign last_o = (idx_q + IDX_W'(1)) == len_q;
  assign more_o = (len_q - idx_q) > IDX_W'(1);

  assert_idx_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= len_q);
  assert_advance_in_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    advance_i |-> idx_q < len_q);
endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl
  import dma_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    start_i,
  input  logic    code_ok_i,
  input  logic    halted_i,
  input  logic    err_i,
  input  logic    gnt_i,
  input  logic    rdy_i,
  input  logic    abrt_i,
  input  logic    last_i,
  output dma_st_e state_o,
  output logic    load_o,
  output logic    advance_o,
  output logic    done_o
);
  dma_st_e state_q, state_d;
  logic    done_q, done_d;

  always_comb begin
    state_d   = state_q;
    load_o    = 1'b0;
    advance_o = 1'b0;
    done_d    = 1'b0;
    if (state_q != ST_IDLE && err_i) begin
      state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i && code_ok_i && !halted_i && !err_i) begin
          state_d = ST_GAP;
          load_o  = 1'b1;
        end
        ST_GAP:  if (!gnt_i) state_d = ST_REQ;
        ST_REQ:  if (gnt_i) state_d = ST_ADDR;
        ST_ADDR: state_d = ST_DATA;
        ST_DATA: begin
          if (abrt_i) begin
            state_d = ST_GAP;
          end else if (rdy_i) begin
            advance_o = 1'b1;
            if (last_i) begin
              state_d = ST_IDLE;
              done_d  = 1'b1;
            end
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign state_o = state_q;
  assign done_o  = done_q;

  assert_done_leaves_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> state_q == ST_IDLE);
endmodule

// File: rtl/burst_dma_master.sv
module burst_dma_master
  import dma_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [DATA_W-1:0]   start_addr_i,
  input  logic                start_rd_i,
  input  logic [2:0]          start_size_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [LEN_W-1:0]    word_idx_o,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                rdata_vld_o,
  output logic [LEN_W-1:0]    rdata_idx_o,
  output logic                par_err_o,
  output logic                busy_o,
  output logic                done_o,
  input  logic                par_en_i,
  input  logic                par_odd_i,
  input  logic                par_byte_i,
  input  logic                early_i,
  input  logic                err_mask_i,
  input  logic                err_clr_i,
  output logic                err_status_o,
  output logic                irq_o,
  output logic                req_n_o,
  input  logic                gnt_n_i,
  input  logic                rdy_n_i,
  input  logic                abrt_n_i,
  input  logic                err_n_i,
  output logic                dir_o,
  output logic [2:0]          size_o,
  output logic [DATA_W-1:0]   ad_o,
  output logic                ad_oe_o,
  input  logic [DATA_W-1:0]   ad_i,
  output logic [DATA_W/8-1:0] par_o,
  output logic [DATA_W/8-1:0] par_oe_o,
  input  logic [DATA_W/8-1:0] par_i
);
  localparam int unsigned NB    = DATA_W / 8;
  localparam int unsigned SHIFT = $clog2(NB);

  dma_st_e           state;
  logic              load, advance, last, more;
  logic [DATA_W-1:0] cur_addr;
  logic [LEN_W-1:0]  idx;
  logic              dir_q, halted_q, rdy_q, abrt_q;
  logic [2:0]        size_q;
  logic              eff_rdy, eff_abrt;
  logic [NB-1:0]     gen_par, gen_use, chk_par, chk_use;
  logic              par_bad;
  logic [DATA_W-1:0] rdata_q;
  logic [LEN_W-1:0]  ridx_q;
  logic              rvld_q, perr_q;

  // early mode: registered copies qualify the current data cycle
  assign eff_abrt = early_i ? abrt_q : ~abrt_n_i;
  assign eff_rdy  = (early_i ? rdy_q : ~rdy_n_i) & ~eff_abrt;

  dma_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .code_ok_i (code_to_len(start_size_i) != '0),
    .halted_i  (halted_q),
    .err_i     (~err_n_i),
    .gnt_i     (~gnt_n_i),
    .rdy_i     (eff_rdy),
    .abrt_i    (eff_abrt),
    .last_i    (last),
    .state_o   (state),
    .load_o    (load),
    .advance_o (advance),
    .done_o    (done_o)
  );

  dma_beat_ctr #(
    .ADDR_W (DATA_W),
    .IDX_W  (LEN_W),
    .SHIFT  (SHIFT)
  ) u_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .base_i    (start_addr_i),
    .len_i     (code_to_len(start_size_i)),
    .advance_i (advance),
    .idx_o     (idx),
    .addr_o    (cur_addr),
    .last_o    (last),
    .more_o    (more)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q    <= 1'b1;
      size_q   <= '0;
      halted_q <= 1'b0;
      rdy_q    <= 1'b0;
      abrt_q   <= 1'b0;
    end else begin
      rdy_q  <= ~rdy_n_i;
      abrt_q <= ~abrt_n_i;
      if (load) begin
        dir_q  <= start_rd_i;
        size_q <= start_size_i;
      end
      if (!err_n_i && !err_mask_i) halted_q <= 1'b1;
      else if (err_clr_i)          halted_q <= 1'b0;
    end
  end

  assign busy_o       = state != ST_IDLE;
  assign req_n_o      = !(state == ST_REQ || ((state == ST_ADDR || state == ST_DATA) && more));
  assign ad_oe_o      = (state == ST_ADDR) || (state == ST_DATA && !dir_q);
  assign ad_o         = (state == ST_ADDR) ? cur_addr : (ad_oe_o ? wdata_i : '0);
  assign word_idx_o   = idx;
  assign dir_o        = dir_q;
  assign size_o       = size_q;
  assign err_status_o = halted_q;
  assign irq_o        = halted_q;

  dma_parity #(.DATA_W(DATA_W)) u_par_gen (
    .word_i (ad_o),
    .en_i   (par_en_i),
    .odd_i  (par_odd_i),
    .byte_i (par_byte_i),
    .par_o  (gen_par),
    .use_o  (gen_use)
  );

  dma_parity #(.DATA_W(DATA_W)) u_par_chk (
    .word_i (ad_i),
    .en_i   (par_en_i),
    .odd_i  (par_odd_i),
    .byte_i (par_byte_i),
    .par_o  (chk_par),
    .use_o  (chk_use)
  );

  assign par_o    = ad_oe_o ? gen_par : '0;
  assign par_oe_o = ad_oe_o ? gen_use : '0;
  assign par_bad  = |((chk_par ^ par_i) & chk_use);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      ridx_q  <= '0;
      rvld_q  <= 1'b0;
      perr_q  <= 1'b0;
    end else begin
      rvld_q <= advance && dir_q;
      perr_q <= advance && dir_q && par_bad;
      if (advance && dir_q) begin
        rdata_q <= ad_i;
        ridx_q  <= idx;
      end
    end
  end

  assign rdata_o     = rdata_q;
  assign rdata_idx_o = ridx_q;
  assign rdata_vld_o = rvld_q;
  assign par_err_o   = perr_q;

  assert_size_legal_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (size_o != 3'b110 && size_o != 3'b111));
  assert_dir_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(dir_o));
  assert_addr_after_grant_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_ADDR) |-> !$past(gnt_n_i));
  assert_req_after_gnt_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(req_n_o) |-> $past(gnt_n_i));
  assert_abort_drops_req_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_DATA && eff_abrt) |=> (req_n_o && !ad_oe_o));
  assert_err_halts_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_n_i |=> (!busy_o && req_n_o && !ad_oe_o));
  assert_refuse_halted_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_status_o && !busy_o) |=> !busy_o);
endmodule

// File: tb/tb_burst_dma_master.sv
module tb_burst_dma_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] addr_in = '0;
  logic        rd_in = 1'b0;
  logic [2:0]  size_in = '0;
  logic [31:0] wdata;
  logic [4:0]  word_idx, rdata_idx;
  logic [31:0] rdata, ad_o, ad_i = '0;
  logic        rdata_vld, par_err, busy, done, err_status, irq;
  logic        par_en = 1'b1, par_odd = 1'b0, par_byte = 1'b1, early = 1'b0;
  logic        err_mask = 1'b0, err_clr = 1'b0;
  logic        req_n, gnt_n = 1'b1, rdy_n = 1'b1, abrt_n = 1'b1, err_n = 1'b1;
  logic        dir, ad_oe;
  logic [2:0]  size;
  logic [3:0]  par_o, par_oe, par_i = '0;

  int nchk = 0, nerr = 0, cyc = 0;
  int rdy_pat = 0, gnt_hold = 0, gcnt = 0, abort_idx = -1;
  bit abort_fired = 0, bad_par = 0;
  int done_cnt = 0, perr_cnt = 0;

  // reference model state
  int          m_ph, m_idx, m_len, m_ridx;
  logic [31:0] m_base, m_rdata;
  logic        m_dir, m_halt, m_rq, m_aq, m_done, m_rv, m_perr;
  logic [2:0]  m_size;
  logic        ea, er, ok;

  always #4 clk = ~clk;

  function automatic logic [31:0] wpat(input int i);
    return 32'hBEEF_0000 + 32'(i) * 32'h0101_0101;
  endfunction
  function automatic logic [31:0] rpat(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A3C, ~a[15:0]};
  endfunction
  function automatic int code_len(input logic [2:0] c);
    case (c)
      3'd0: return 1;  3'd1: return 2;  3'd2: return 4;
      3'd3: return 8;  3'd4: return 16; 3'd5: return 12;
      default: return 0;
    endcase
  endfunction
  function automatic logic [3:0] use_mask();
    if (!par_en) return 4'b0000;
    return par_byte ? 4'b1111 : 4'b1000;
  endfunction
  function automatic logic [3:0] exp_par(input logic [31:0] w);
    logic [3:0] p;
    for (int b = 0; b < 4; b++) p[b] = (^w[8*b +: 8]) ^ par_odd;
    if (!par_byte) p = {(^w) ^ par_odd, 3'b000};
    return p & use_mask();
  endfunction

  assign wdata = wpat(int'(word_idx));

  burst_dma_master dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_addr_i(addr_in),
    .start_rd_i(rd_in), .start_size_i(size_in), .wdata_i(wdata),
    .word_idx_o(word_idx), .rdata_o(rdata), .rdata_vld_o(rdata_vld),
    .rdata_idx_o(rdata_idx), .par_err_o(par_err), .busy_o(busy), .done_o(done),
    .par_en_i(par_en), .par_odd_i(par_odd), .par_byte_i(par_byte), .early_i(early),
    .err_mask_i(err_mask), .err_clr_i(err_clr), .err_status_o(err_status), .irq_o(irq),
    .req_n_o(req_n), .gnt_n_i(gnt_n), .rdy_n_i(rdy_n), .abrt_n_i(abrt_n), .err_n_i(err_n),
    .dir_o(dir), .size_o(size), .ad_o(ad_o), .ad_oe_o(ad_oe), .ad_i(ad_i),
    .par_o(par_o), .par_oe_o(par_oe), .par_i(par_i)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference, advanced at each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_idx = 0; m_len = 0; m_base = '0; m_dir = 1'b1; m_size = '0;
      m_halt = 0; m_rq = 0; m_aq = 0; m_done = 0; m_rv = 0; m_perr = 0;
      m_rdata = '0; m_ridx = 0;
    end else begin
      ea = early ? m_aq : !abrt_n;
      er = (early ? m_rq : !rdy_n) && !ea;
      m_rq = !rdy_n; m_aq = !abrt_n;
      m_done = 0; m_rv = 0; m_perr = 0;
      ok = start && !m_halt && err_n && code_len(size_in) != 0;
      if (m_ph != 0 && !err_n) m_ph = 0;
      else case (m_ph)
        0: if (ok) begin
          m_ph = 1; m_base = addr_in; m_len = code_len(size_in); m_idx = 0;
          m_dir = rd_in; m_size = size_in;
        end
        1: if (gnt_n) m_ph = 2;
        2: if (!gnt_n) m_ph = 3;
        3: m_ph = 4;
        4: if (ea) m_ph = 1;
           else if (er) begin
             if (m_dir) begin
               m_rv = 1; m_ridx = m_idx; m_rdata = rpat(m_base + 32'(m_idx) * 4);
               m_perr = bad_par && par_en;
             end
             m_idx++;
             if (m_idx == m_len) begin m_ph = 0; m_done = 1; end
           end
        default: m_ph = 0;
      endcase
      if (!err_n && !err_mask) m_halt = 1;
      else if (err_clr) m_halt = 0;
    end
  end

  // compare on every clock, then act as arbiter and target
  always @(negedge clk) begin
    logic [31:0] e_ad;
    logic        e_oe;
    cyc++;
    if (rst_n) begin
      e_oe = (m_ph == 3) || (m_ph == 4 && !m_dir);
      e_ad = (m_ph == 3) ? m_base + 32'(m_idx) * 4 : wpat(m_idx);
      chk("R3 req_n", req_n, !(m_ph == 2 || ((m_ph == 3 || m_ph == 4) && (m_len - m_idx) > 1)));
      chk("R6 busy", busy, m_ph != 0);
      chk("R2 dir", dir, m_dir);
      chk("R1 size", size, m_size);
      chk("R5 ad_oe", ad_oe, e_oe);
      if (e_oe) begin
        chk("R5 ad", ad_o, e_ad);
        chk("R10 par", par_o, exp_par(e_ad));
      end
      chk("R10 par_oe", par_oe, e_oe ? use_mask() : 4'b0000);
      chk("R6 done", done, m_done);
      chk("R6 rdata_vld", rdata_vld, m_rv);
      if (m_rv) begin
        chk("R6 rdata", rdata, m_rdata);
        chk("R6 rdata_idx", rdata_idx, 32'(m_ridx));
        chk("R11 par_err", par_err, m_perr);
      end
      chk("R9 irq", irq, m_halt);
      if (done) done_cnt++;
      if (par_err) perr_cnt++;
    end
    if (req_n) begin gnt_n = 1'b1; gcnt = gnt_hold; end
    else if (gcnt > 0) gcnt--;
    else gnt_n = 1'b0;
    case (rdy_pat)
      1: rdy_n = cyc[0];
      2: rdy_n = (cyc % 3) == 0;
      default: rdy_n = 1'b0;
    endcase
    abrt_n = 1'b1;
    if (abort_idx >= 0 && !abort_fired && m_ph == 4 && m_idx == abort_idx) begin
      abrt_n = 1'b0; abort_fired = 1;
    end
    ad_i  = rpat(m_base + 32'(m_idx) * 4);
    par_i = exp_par(ad_i) ^ (bad_par ? 4'b1000 : 4'b0000);
  end

  task automatic issue(input logic [31:0] a, input logic rd, input logic [2:0] c);
    @(negedge clk);
    start = 1'b1; addr_in = a; rd_in = rd; size_in = c;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run(input string tag, input logic [31:0] a, input logic rd, input logic [2:0] c);
    int d0, g;
    d0 = done_cnt; abort_fired = 0;
    issue(a, rd, c);
    g = 0;
    while (m_ph != 0 && g < 2000) begin @(negedge clk); g++; end
    repeat (2) @(negedge clk);
    chk(tag, done_cnt - d0, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 reset dir", dir, 1);
    chk("R1 reset size", size, 0);
    chk("R3 reset req_n", req_n, 1);
    chk("R5 reset ad_oe", ad_oe, 0);

    run("R6 write 4 even byte parity", 32'h0000_1000, 1'b0, 3'b010);
    par_odd = 1; par_byte = 0; rdy_pat = 1; gnt_hold = 2;
    run("R6 read 12 odd word parity stalls", 32'h0000_2000, 1'b1, 3'b101);
    early = 1; rdy_pat = 2; gnt_hold = 0; par_byte = 1;
    run("R8 write 16 early", 32'h0000_3000, 1'b0, 3'b100);
    early = 0; rdy_pat = 0; abort_idx = 3;
    run("R7 read 8 abort resume", 32'h0000_4000, 1'b1, 3'b011);
    early = 1; abort_idx = 5; rdy_pat = 1;
    run("R7 R8 read 8 early abort", 32'h0000_5000, 1'b1, 3'b011);
    early = 0; abort_idx = 1; rdy_pat = 0;
    run("R7 write 4 abort", 32'h0000_5800, 1'b0, 3'b010);
    abort_idx = -1;
    run("R6 read single", 32'h0000_6000, 1'b1, 3'b000);
    run("R6 write pair", 32'h0000_6100, 1'b0, 3'b001);

    issue(32'h7000, 1'b1, 3'b110);
    repeat (3) @(negedge clk);
    chk("R1 code 110 refused", busy, 0);
    issue(32'h7000, 1'b1, 3'b111);
    repeat (3) @(negedge clk);
    chk("R1 code 111 refused", busy, 0);

    bad_par = 1; perr_cnt = 0;
    run("R11 read bad parity", 32'h0000_8000, 1'b1, 3'b001);
    chk("R11 parity error count", perr_cnt, 2);
    bad_par = 0; par_en = 0;
    run("R10 write parity off", 32'h0000_8800, 1'b0, 3'b010);
    par_en = 1;

    // bus error mid burst
    issue(32'h0000_9000, 1'b1, 3'b011);
    while (!(m_ph == 4 && m_idx == 3)) @(negedge clk);
    err_n = 1'b0;
    @(negedge clk);
    err_n = 1'b1;
    chk("R9 halted busy", busy, 0);
    chk("R9 status", err_status, 1);
    chk("R9 irq", irq, 1);
    issue(32'h0000_9100, 1'b0, 3'b000);
    repeat (3) @(negedge clk);
    chk("R12 refused while halted", busy, 0);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    chk("R12 status cleared", err_status, 0);
    run("R12 accepted after clear", 32'h0000_9200, 1'b0, 3'b001);

    err_mask = 1;
    issue(32'h0000_A000, 1'b0, 3'b010);
    while (m_ph != 4) @(negedge clk);
    err_n = 1'b0;
    @(negedge clk);
    err_n = 1'b1;
    chk("R9 masked halt", busy, 0);
    chk("R9 masked no irq", irq, 0);
    run("R9 masked then accepted", 32'h0000_A100, 1'b1, 3'b001);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule